// File: doc/BRIEF.md
# Low-Power 32-bit Real-Time Counter

This block is a free-running 32-bit up-counter paced by a slow real-time clock, with one period register that sets the wrap point and one compare register that raises an alarm. Software reaches it over an 8-bit register bus on the fast peripheral clock. Every 32-bit value is split into four byte lanes. Lower lanes are only staged. Writing the top lane (lane 3) commits the whole word, and it then crosses into the counting logic with a latency fixed per register. The count is read back through an explicit snapshot request. A busy flag covers control and count transfers.

The slow clock is oversampled in the peripheral domain. A two-stage synchroniser feeds an edge detector, which yields one tick per rising edge and one strobe per falling edge of the slow clock. A debug halt input suppresses both, so the counter freezes while the core is stopped. Overflow and compare each drive a sticky interrupt flag and a one-cycle event pulse.

Register map: group in address bits [3:2] (0 control, 1 count, 2 period, 3 compare), byte lane in bits [1:0]. Control group offsets: 0 holds the enable bit in bit 0, 1 holds the sync register (bit 0 busy, read only; bit 1 snapshot request, write 1), 2 holds the flags (bit 0 overflow, bit 1 compare, write 1 to clear).

Top module: `rtc32_core`

## Requirements
- R1: After reset the enable bit, busy flag, both flags, the count and its snapshot are zero, and the period and compare registers read all ones.
- R2: Writing count lanes 0 to 2 changes nothing in the running counter. Writing lane 3 loads the full staged word into the counter exactly 12 peripheral clocks after the write edge. Busy is high from the write edge until that load.
- R3: Writing 1 to sync bit 1 captures the counter into the snapshot exactly 8 peripheral clocks after the write edge. Busy is high until then, and the count lanes read the snapshot.
- R4: A write to the enable bit takes effect on the next falling edge of the slow clock. Busy stays high until then, and a slow-clock rising edge before that falling edge is not counted.
- R5: Each slow-clock rising edge advances an enabled counter by one. A disabled counter holds its value.
- R6: On a tick where the count equals the active period, the counter returns to zero, flag bit 0 sets, irq_ovf goes high and evt_ovf pulses for one peripheral clock.
- R7: On a tick where the count equals the active compare value, flag bit 1 sets, irq_cmp goes high and evt_cmp pulses for one peripheral clock. The alarm therefore appears on the count after the matching one.
- R8: A period or compare word committed by its lane 3 write becomes active on the second following tick, so it is first used on the third tick. Lower-lane writes alone never change the active value, and these writes do not set busy.
- R9: Flags stay set until 1 is written to their bit. Writing 0 leaves them unchanged.
- R10: Slow-clock edges seen while dbg_halt is high are ignored: the count does not move and no event is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rtc_clk | input | 1 | Slow real-time clock, oversampled |
| dbg_halt | input | 1 | Debug halt, freezes counting |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_ovf | output | 1 | Overflow interrupt flag |
| irq_cmp | output | 1 | Compare interrupt flag |
| evt_ovf | output | 1 | Overflow event pulse |
| evt_cmp | output | 1 | Compare event pulse |

## Verification
The bench builds the block with its defaults: 32-bit count, 12-clock count load, 8-clock snapshot, two-tick period and compare activation, and two synchroniser stages. It drives the slow clock at one sixteenth of the peripheral clock. This puts every slow edge inside a known window, so the busy flag can be checked clock by clock against the 12- and 8-cycle latencies. Short period and compare values bring the wrap and the delayed alarm within a few ticks. Loading the count just below the old period shows that a new period is not used until its third tick.

// File: rtl/rtc32_pkg.sv
package rtc32_pkg;
    // Register groups selected by the two upper address bits.
    typedef enum logic [1:0] {
        GRP_CTL = 2'd0,
        GRP_CNT = 2'd1,
        GRP_PER = 2'd2,
        GRP_CMP = 2'd3
    } grp_e;

    // Offsets inside the control group.
    localparam int OFS_CTRL  = 0;
    localparam int OFS_SYNC  = 1;
    localparam int OFS_FLAGS = 2;

    // Bit positions.
    localparam int SYNC_RDREQ_BIT = 1;
    localparam int FLAG_OVF_BIT   = 0;
    localparam int FLAG_CMP_BIT   = 1;

    // Channel indices for the delayed-activation registers.
    localparam int CH_PER = 0;
    localparam int CH_CMP = 1;
    localparam int N_CH   = 2;
endpackage

// File: rtl/rtc32_edge_sync.sv
// Oversamples the slow real-time clock on the peripheral clock.
// Produces a one-cycle tick per rising edge and a strobe per falling edge.
// Both are suppressed while dbg_halt is high.
// Assumes pclk is at least several times faster than rtc_clk (STAGES >= 2).
module rtc32_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic pclk,
    input  logic rst_n,
    input  logic rtc_clk,
    input  logic dbg_halt,
    output logic tick,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the slow clock through the synchroniser and remember the last level.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], rtc_clk};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Edge strobes, gated by the debug halt.
    always_comb begin
        tick = sync_q[STAGES-1] & ~last_q & ~dbg_halt;
        fall = ~sync_q[STAGES-1] & last_q & ~dbg_halt;
    end
endmodule

// File: rtl/rtc32_stage.sv
// Byte-lane staging for one wide register.
// Lower lanes are stored. A write to the top lane raises commit and
// presents the full word (top byte taken straight from the bus).
module rtc32_stage #(
    parameter int               CNT_W   = 32,
    parameter logic [CNT_W-1:0] RST_VAL = '0,
    localparam int              NBYTES  = CNT_W / 8,
    localparam int              LANE_W  = $clog2(NBYTES)
) (
    input  logic              pclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        wdata,
    output logic [CNT_W-1:0]  stage_q,
    output logic              commit,
    output logic [CNT_W-1:0]  commit_val
);
    localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(NBYTES - 1);

    // Store the addressed byte lane.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            stage_q <= RST_VAL;
        end else if (wr_en) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (lane == LANE_W'(i)) stage_q[i*8 +: 8] <= wdata;
            end
        end
    end

    // Commit strobe and assembled word on a top-lane write.
    always_comb begin
        commit     = wr_en && (lane == TOP_LANE);
        commit_val = {wdata, stage_q[CNT_W-9:0]};
    end
endmodule

// File: rtl/rtc32_sync_ctl.sv
// Transfer timing for count loads, count snapshots and the enable bit.
// Count load lands WR_LAT cycles after the commit edge; snapshot RD_LAT
// cycles after the request edge; enable applies on the next slow falling edge.
// busy covers these three transfers only.
module rtc32_sync_ctl #(
    parameter int CNT_W  = 32,
    parameter int WR_LAT = 12,
    parameter int RD_LAT = 8
) (
    input  logic             pclk,
    input  logic             rst_n,
    input  logic             cnt_commit,
    input  logic [CNT_W-1:0] cnt_commit_val,
    input  logic             rd_req,
    input  logic             ctrl_wr,
    input  logic             ctrl_wbit,
    input  logic             rtc_fall,
    input  logic [CNT_W-1:0] cnt_now,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_load_val,
    output logic [CNT_W-1:0] snap_q,
    output logic             ctrl_stage_q,
    output logic             en_q,
    output logic             busy
);
    localparam int MAX_LAT = (WR_LAT > RD_LAT) ? WR_LAT : RD_LAT;
    localparam int TMR_W   = $clog2(MAX_LAT + 1);

    logic             wr_act_q, rd_act_q, ctrl_pend_q;
    logic [TMR_W-1:0] wr_tmr_q, rd_tmr_q;
    logic             rd_done;

    // Count-write countdown and hold of the committed word.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            wr_act_q     <= 1'b0;
            wr_tmr_q     <= '0;
            cnt_load_val <= '0;
        end else if (cnt_commit) begin
            wr_act_q     <= 1'b1;
            wr_tmr_q     <= TMR_W'(WR_LAT - 1);
            cnt_load_val <= cnt_commit_val;
        end else if (wr_act_q) begin
            if (wr_tmr_q == '0) wr_act_q <= 1'b0;
            else                wr_tmr_q <= wr_tmr_q - 1'b1;
        end
    end

    // Snapshot countdown and capture.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            rd_tmr_q <= '0;
            snap_q   <= '0;
        end else if (rd_req) begin
            rd_act_q <= 1'b1;
            rd_tmr_q <= TMR_W'(RD_LAT - 1);
        end else if (rd_act_q) begin
            if (rd_done) begin
                rd_act_q <= 1'b0;
                snap_q   <= cnt_now;
            end else begin
                rd_tmr_q <= rd_tmr_q - 1'b1;
            end
        end
    end

    // Enable bit staging, applied on a slow falling edge.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            ctrl_stage_q <= 1'b0;
            ctrl_pend_q  <= 1'b0;
            en_q         <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_stage_q <= ctrl_wbit;
            ctrl_pend_q  <= 1'b1;
        end else if (ctrl_pend_q && rtc_fall) begin
            en_q        <= ctrl_stage_q;
            ctrl_pend_q <= 1'b0;
        end
    end

    // Completion strobes and the combined busy flag.
    always_comb begin
        cnt_load = wr_act_q && (wr_tmr_q == '0);
        rd_done  = rd_tmr_q == '0;
        busy     = wr_act_q | rd_act_q | ctrl_pend_q;
    end
endmodule

// File: rtl/rtc32_counter.sv
// The counter with its period wrap and compare alarm.
// Period and compare words are held after commit and become active on the
// APPLY_TICKS-th following tick. Events are registered one-cycle pulses.
module rtc32_counter
    import rtc32_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int APPLY_TICKS = 2
) (
    input  logic                       pclk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       en,
    input  logic                       load,
    input  logic [CNT_W-1:0]           load_val,
    input  logic [N_CH-1:0]            ch_commit,
    input  logic [N_CH-1:0][CNT_W-1:0] ch_val,
    output logic [CNT_W-1:0]           cnt_q,
    output logic                       ovf_evt_q,
    output logic                       cmp_evt_q
);
    localparam int PEND_W = $clog2(APPLY_TICKS + 1);

    logic [N_CH-1:0][CNT_W-1:0]  hold_q;
    logic [N_CH-1:0][CNT_W-1:0]  act_q;
    logic [N_CH-1:0][PEND_W-1:0] pend_q;
    logic                        step, hit_per, hit_cmp;

    // Delayed activation of period and compare words.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            hold_q <= '1;
            act_q  <= '1;
            pend_q <= '0;
        end else begin
            for (int c = 0; c < N_CH; c++) begin
                if (ch_commit[c]) begin
                    hold_q[c] <= ch_val[c];
                    pend_q[c] <= PEND_W'(APPLY_TICKS);
                end else if (tick && pend_q[c] != '0) begin
                    pend_q[c] <= pend_q[c] - 1'b1;
                    if (pend_q[c] == PEND_W'(1)) act_q[c] <= hold_q[c];
                end
            end
        end
    end

    // Match detection against the active values.
    always_comb begin
        step    = tick && en && !load;
        hit_per = cnt_q == act_q[CH_PER];
        hit_cmp = cnt_q == act_q[CH_CMP];
    end

    // Counter update and event pulses.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ovf_evt_q <= 1'b0;
            cmp_evt_q <= 1'b0;
        end else begin
            ovf_evt_q <= step && hit_per;
            cmp_evt_q <= step && hit_cmp;
            if (load)      cnt_q <= load_val;
            else if (step) cnt_q <= hit_per ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc32_core.sv
// Top of the real-time counter: bus decode, staging, transfer timing,
// counter and sticky interrupt flags. All logic runs on pclk; rtc_clk is
// oversampled. Assumes pclk is at least 12 times the rtc_clk rate.
module rtc32_core
    import rtc32_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_WR_LAT  = 12,
    parameter int CNT_RD_LAT  = 8,
    parameter int APPLY_TICKS = 2
) (
    input  logic                           pclk,
    input  logic                           rst_n,
    input  logic                           rtc_clk,
    input  logic                           dbg_halt,
    input  logic                           bus_wr,
    input  logic [$clog2(CNT_W/8)+1:0]     bus_addr,
    input  logic [7:0]                     bus_wdata,
    output logic [7:0]                     bus_rdata,
    output logic                           irq_ovf,
    output logic                           irq_cmp,
    output logic                           evt_ovf,
    output logic                           evt_cmp
);
    localparam int NBYTES = CNT_W / 8;
    localparam int LANE_W = $clog2(NBYTES);
    localparam int ADDR_W = LANE_W + 2;
    localparam int N_WIDE = 3;

    grp_e                             grp;
    logic [LANE_W-1:0]                lane;
    logic [N_WIDE-1:0]                wide_wr;
    logic [N_WIDE-1:0][CNT_W-1:0]     stg_q;
    logic [N_WIDE-1:0]                stg_commit;
    logic [N_WIDE-1:0][CNT_W-1:0]     stg_val;
    logic                             ctrl_wr, rd_req;
    logic [1:0]                       flag_clr, flags_q;
    logic                             tick, rtc_fall;
    logic                             cnt_load, en_q, ctrl_stage_q, sync_busy;
    logic [CNT_W-1:0]                 cnt_load_val, snap_q, cnt_q;
    logic [N_CH-1:0]                  ch_commit;
    logic [N_CH-1:0][CNT_W-1:0]       ch_val;
    logic [LANE_W+2:0]                byte_idx;

    // Address decode into group, lane and write strobes.
    always_comb begin
        grp      = grp_e'(bus_addr[ADDR_W-1:LANE_W]);
        lane     = bus_addr[LANE_W-1:0];
        wide_wr  = '0;
        if (bus_wr && grp != GRP_CTL) wide_wr[grp - 2'd1] = 1'b1;
        ctrl_wr  = bus_wr && grp == GRP_CTL && lane == LANE_W'(OFS_CTRL);
        rd_req   = bus_wr && grp == GRP_CTL && lane == LANE_W'(OFS_SYNC)
                   && bus_wdata[SYNC_RDREQ_BIT];
        flag_clr = (bus_wr && grp == GRP_CTL && lane == LANE_W'(OFS_FLAGS))
                   ? bus_wdata[1:0] : 2'b00;
        byte_idx = {lane, 3'b000};
    end

    // Staging for count (0), period (1) and compare (2).
    for (genvar g = 0; g < N_WIDE; g++) begin : g_stage
        rtc32_stage #(
            .CNT_W  (CNT_W),
            .RST_VAL((g == 0) ? {CNT_W{1'b0}} : {CNT_W{1'b1}})
        ) u_stage (
            .pclk      (pclk),
            .rst_n     (rst_n),
            .wr_en     (wide_wr[g]),
            .lane      (lane),
            .wdata     (bus_wdata),
            .stage_q   (stg_q[g]),
            .commit    (stg_commit[g]),
            .commit_val(stg_val[g])
        );
    end

    rtc32_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .pclk    (pclk),
        .rst_n   (rst_n),
        .rtc_clk (rtc_clk),
        .dbg_halt(dbg_halt),
        .tick    (tick),
        .fall    (rtc_fall)
    );

    rtc32_sync_ctl #(
        .CNT_W (CNT_W),
        .WR_LAT(CNT_WR_LAT),
        .RD_LAT(CNT_RD_LAT)
    ) u_sync (
        .pclk          (pclk),
        .rst_n         (rst_n),
        .cnt_commit    (stg_commit[0]),
        .cnt_commit_val(stg_val[0]),
        .rd_req        (rd_req),
        .ctrl_wr       (ctrl_wr),
        .ctrl_wbit     (bus_wdata[0]),
        .rtc_fall      (rtc_fall),
        .cnt_now       (cnt_q),
        .cnt_load      (cnt_load),
        .cnt_load_val  (cnt_load_val),
        .snap_q        (snap_q),
        .ctrl_stage_q  (ctrl_stage_q),
        .en_q          (en_q),
        .busy          (sync_busy)
    );

    // Route period and compare commits to the counter channels.
    always_comb begin
        ch_commit[CH_PER] = stg_commit[1];
        ch_commit[CH_CMP] = stg_commit[2];
        ch_val[CH_PER]    = stg_val[1];
        ch_val[CH_CMP]    = stg_val[2];
    end

    rtc32_counter #(
        .CNT_W      (CNT_W),
        .APPLY_TICKS(APPLY_TICKS)
    ) u_cnt (
        .pclk     (pclk),
        .rst_n    (rst_n),
        .tick     (tick),
        .en       (en_q),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .ch_commit(ch_commit),
        .ch_val   (ch_val),
        .cnt_q    (cnt_q),
        .ovf_evt_q(evt_ovf),
        .cmp_evt_q(evt_cmp)
    );

    // Sticky flags: events set, write-one clears, set wins.
    always_ff @(posedge pclk) begin
        if (!rst_n) flags_q <= 2'b00;
        else        flags_q <= (flags_q & ~flag_clr) | {evt_cmp, evt_ovf};
    end

    // Interrupt outputs follow the flags.
    always_comb begin
        irq_ovf = flags_q[FLAG_OVF_BIT];
        irq_cmp = flags_q[FLAG_CMP_BIT];
    end

    // Read-data multiplexer.
    always_comb begin
        bus_rdata = 8'h00;
        unique case (grp)
            GRP_CTL: begin
                if (lane == LANE_W'(OFS_CTRL))       bus_rdata = {7'd0, ctrl_stage_q};
                else if (lane == LANE_W'(OFS_SYNC))  bus_rdata = {7'd0, sync_busy};
                else if (lane == LANE_W'(OFS_FLAGS)) bus_rdata = {6'd0, flags_q};
                else                                 bus_rdata = 8'h00;
            end
            GRP_CNT: bus_rdata = snap_q[byte_idx +: 8];
            GRP_PER: bus_rdata = stg_q[1][byte_idx +: 8];
            GRP_CMP: bus_rdata = stg_q[2][byte_idx +: 8];
            default: bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/rtc32_core_chk.sv
// Property checker for rtc32_core, attached by bind below.
module rtc32_core_chk #(
    parameter int CNT_W  = 32,
    localparam int LANE_W = $clog2(CNT_W / 8),
    localparam int ADDR_W = LANE_W + 2
) (
    input logic              pclk,
    input logic              rst_n,
    input logic              dbg_halt,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              irq_ovf,
    input logic              irq_cmp,
    input logic              evt_ovf,
    input logic              evt_cmp,
    input logic              busy
);
    localparam logic [ADDR_W-1:0] CNT_TOP  = {2'd1, {LANE_W{1'b1}}};
    localparam logic [ADDR_W-1:0] PER_TOP  = {2'd2, {LANE_W{1'b1}}};
    localparam logic [ADDR_W-1:0] FLAG_ADR = ADDR_W'(2);

    a_r2_cnt_top_sets_busy: assert property (@(posedge pclk) disable iff (!rst_n)
        (bus_wr && bus_addr == CNT_TOP) |=> busy);

    a_r8_per_top_no_busy: assert property (@(posedge pclk) disable iff (!rst_n)
        (bus_wr && bus_addr == PER_TOP && !busy) |=> !busy);

    a_r6_ovf_pulse_single: assert property (@(posedge pclk) disable iff (!rst_n)
        evt_ovf |=> !evt_ovf);

    a_r7_cmp_pulse_single: assert property (@(posedge pclk) disable iff (!rst_n)
        evt_cmp |=> !evt_cmp);

    a_r6_ovf_sets_irq: assert property (@(posedge pclk) disable iff (!rst_n)
        evt_ovf |=> irq_ovf);

    a_r7_cmp_sets_irq: assert property (@(posedge pclk) disable iff (!rst_n)
        evt_cmp |=> irq_cmp);

    a_r9_ovf_sticky: assert property (@(posedge pclk) disable iff (!rst_n)
        (irq_ovf && !(bus_wr && bus_addr == FLAG_ADR && bus_wdata[0])) |=> irq_ovf);

    a_r9_cmp_sticky: assert property (@(posedge pclk) disable iff (!rst_n)
        (irq_cmp && !(bus_wr && bus_addr == FLAG_ADR && bus_wdata[1])) |=> irq_cmp);

    a_r10_halt_no_event: assert property (@(posedge pclk) disable iff (!rst_n)
        $past(dbg_halt) |-> !(evt_ovf || evt_cmp));
endmodule

bind rtc32_core rtc32_core_chk #(.CNT_W(CNT_W)) u_chk (
    .pclk     (pclk),
    .rst_n    (rst_n),
    .dbg_halt (dbg_halt),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .irq_ovf  (irq_ovf),
    .irq_cmp  (irq_cmp),
    .evt_ovf  (evt_ovf),
    .evt_cmp  (evt_cmp),
    .busy     (sync_busy)
);

// File: tb/tb_rtc32_core.sv
module tb_rtc32_core;
    logic       pclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rtc_clk = 1'b0;
    logic       dbg_halt = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_ovf, irq_cmp, evt_ovf, evt_cmp;

    int checks = 0;
    int failures = 0;
    logic [1:0] exp_q[$];
    logic [1:0] ev_prev = 2'b00;

    localparam logic [3:0] A_CTRL = 4'h0, A_SYNC = 4'h1, A_FLAGS = 4'h2;
    localparam logic [1:0] G_CNT = 2'd1, G_PER = 2'd2, G_CMP = 2'd3;

    always #4 pclk = ~pclk;

    rtc32_core dut (
        .pclk(pclk), .rst_n(rst_n), .rtc_clk(rtc_clk), .dbg_halt(dbg_halt),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp),
        .evt_ovf(evt_ovf), .evt_cmp(evt_cmp)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge pclk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge pclk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic write_wide(input logic [1:0] g, input logic [31:0] v);
        for (int i = 0; i < 4; i++) bus_write({g, 2'(i)}, v[i*8 +: 8]);
    endtask

    task automatic read_wide(input logic [1:0] g, output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            bus_read({g, 2'(i)}, b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic busy_now(output logic [31:0] v);
        logic [7:0] b;
        bus_read(A_SYNC, b);
        v = {31'd0, b[0]};
    endtask

    task automatic load_count(input logic [31:0] v);
        write_wide(G_CNT, v);
        repeat (12) @(negedge pclk);
    endtask

    task automatic read_count(output logic [31:0] v);
        bus_write(A_SYNC, 8'h02);
        repeat (8) @(negedge pclk);
        read_wide(G_CNT, v);
    endtask

    task automatic read_flags(output logic [31:0] v);
        logic [7:0] b;
        bus_read(A_FLAGS, b);
        v = {24'd0, b};
    endtask

    // Driver: one slow-clock period, pushing the event it should cause.
    task automatic rtc_pulse(input logic [1:0] expect_ev);
        if (expect_ev != 2'b00) exp_q.push_back(expect_ev);
        rtc_clk = 1'b1;
        repeat (8) @(negedge pclk);
        rtc_clk = 1'b0;
        repeat (8) @(negedge pclk);
    endtask

    // Monitor: every event pulse is matched against the scoreboard queue.
    always @(negedge pclk) begin
        if (rst_n && (evt_ovf || evt_cmp)) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R6/R7 event: got %b expected none", {evt_cmp, evt_ovf});
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                if (e !== {evt_cmp, evt_ovf}) begin
                    failures++;
                    $display("FAIL R6/R7 event: got %b expected %b", {evt_cmp, evt_ovf}, e);
                end
            end
            if (ev_prev != 2'b00) begin
                failures++;
                $display("FAIL R6/R7 pulse width: got 2 cycles expected 1");
            end
        end
        ev_prev = rst_n ? {evt_cmp, evt_ovf} : 2'b00;
    end

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge pclk);
        rst_n = 1'b1;
        @(negedge pclk);

        // R1 reset state
        bus_read(A_CTRL, v[7:0]); check("R1 ctrl", {24'd0, v[7:0]}, 32'd0);
        busy_now(v); check("R1 busy", v, 32'd0);
        read_flags(v); check("R1 flags", v, 32'd0);
        read_wide(G_CNT, v); check("R1 snapshot", v, 32'd0);
        read_wide(G_PER, v); check("R1 period", v, 32'hFFFF_FFFF);
        read_wide(G_CMP, v); check("R1 compare", v, 32'hFFFF_FFFF);
        check("R1 irq", {30'd0, irq_cmp, irq_ovf}, 32'd0);

        // R2 lower lanes only stage
        bus_write({G_CNT, 2'd0}, 8'h44);
        bus_write({G_CNT, 2'd1}, 8'h33);
        bus_write({G_CNT, 2'd2}, 8'h22);
        busy_now(v); check("R2 lower lanes no busy", v, 32'd0);
        read_count(v); check("R2 lower lanes no load", v, 32'd0);

        // R2 top lane: busy for exactly 12 clocks
        bus_write({G_CNT, 2'd3}, 8'h11);
        busy_now(v); check("R2 busy at commit", v, 32'd1);
        for (int k = 1; k <= 12; k++) begin
            @(negedge pclk);
            busy_now(v);
            check($sformatf("R2 busy k=%0d", k), v, (k < 12) ? 32'd1 : 32'd0);
        end

        // R3 snapshot request: busy for exactly 8 clocks, then value
        bus_write(A_SYNC, 8'h02);
        for (int k = 1; k <= 8; k++) begin
            @(negedge pclk);
            busy_now(v);
            check($sformatf("R3 busy k=%0d", k), v, (k < 8) ? 32'd1 : 32'd0);
        end
        read_wide(G_CNT, v); check("R3 R2 loaded value", v, 32'h1122_3344);

        // R5 disabled counter holds
        rtc_pulse(2'b00); rtc_pulse(2'b00);
        read_count(v); check("R5 disabled holds", v, 32'h1122_3344);

        // R4 enable waits for the slow falling edge
        bus_write(A_CTRL, 8'h01);
        rtc_clk = 1'b1;
        repeat (8) @(negedge pclk);
        busy_now(v); check("R4 busy before fall", v, 32'd1);
        rtc_clk = 1'b0;
        repeat (8) @(negedge pclk);
        busy_now(v); check("R4 busy after fall", v, 32'd0);
        bus_read(A_CTRL, v[7:0]); check("R4 ctrl reads 1", {24'd0, v[7:0]}, 32'd1);
        read_count(v); check("R4 edge before enable not counted", v, 32'h1122_3344);

        // R5 counting
        rtc_pulse(2'b00); rtc_pulse(2'b00); rtc_pulse(2'b00);
        read_count(v); check("R5 three ticks", v, 32'h1122_3347);

        // R6 period wrap
        write_wide(G_PER, 32'd5);
        load_count(32'd3);
        rtc_pulse(2'b00); rtc_pulse(2'b00);
        read_count(v); check("R6 before wrap", v, 32'd5);
        read_flags(v); check("R6 flag clear before wrap", v, 32'd0);
        rtc_pulse(2'b01);
        read_count(v); check("R6 wrapped to zero", v, 32'd0);
        read_flags(v); check("R6 overflow flag", v, 32'd1);
        check("R6 irq_ovf", {31'd0, irq_ovf}, 32'd1);

        // R9 write 0 keeps, write 1 clears
        bus_write(A_FLAGS, 8'h00);
        read_flags(v); check("R9 write zero keeps", v, 32'd1);
        bus_write(A_FLAGS, 8'h01);
        read_flags(v); check("R9 write one clears", v, 32'd0);

        // R8 new period first used on the third tick
        load_count(32'd4);
        write_wide(G_PER, 32'd100);
        busy_now(v); check("R8 period commit no busy", v, 32'd0);
        rtc_pulse(2'b00);
        read_count(v); check("R8 tick1 old period", v, 32'd5);
        rtc_pulse(2'b01);
        read_count(v); check("R8 tick2 still old period", v, 32'd0);
        rtc_pulse(2'b00);
        read_count(v); check("R8 tick3 new period", v, 32'd1);
        bus_write(A_FLAGS, 8'h01);

        // R8 lower period lane alone has no effect
        bus_write({G_PER, 2'd0}, 8'h01);
        bus_read({G_PER, 2'd0}, v[7:0]); check("R8 lane staged", {24'd0, v[7:0]}, 32'h01);
        rtc_pulse(2'b00); rtc_pulse(2'b00); rtc_pulse(2'b00);
        read_count(v); check("R8 lower lane ignored", v, 32'd4);
        read_flags(v); check("R8 no overflow from lower lane", v, 32'd0);
        write_wide(G_PER, 32'd100);
        rtc_pulse(2'b00); rtc_pulse(2'b00);

        // R7 compare fires on the tick after the matching count
        load_count(32'd10);
        write_wide(G_CMP, 32'd12);
        rtc_pulse(2'b00); rtc_pulse(2'b00);
        read_count(v); check("R7 at match count", v, 32'd12);
        read_flags(v); check("R7 no flag yet", v, 32'd0);
        rtc_pulse(2'b10);
        read_flags(v); check("R7 compare flag", v, 32'd2);
        check("R7 irq_cmp", {31'd0, irq_cmp}, 32'd1);
        read_count(v); check("R7 count moved past", v, 32'd13);

        // R10 debug halt freezes
        dbg_halt = 1'b1;
        rtc_pulse(2'b00); rtc_pulse(2'b00); rtc_pulse(2'b00);
        dbg_halt = 1'b0;
        read_count(v); check("R10 halted", v, 32'd13);
        rtc_pulse(2'b00);
        read_count(v); check("R10 resumes", v, 32'd14);

        repeat (4) @(negedge pclk);
        check("R6 R7 scoreboard drained", exp_q.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule